// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block merges the interrupt causes of a UART into a single request line and reports which cause is the most urgent through a 4-bit identification code. It keeps the interrupt enable register and a latched "transmit holding stage empty" flag. It compares the receive fill count against a selectable trigger level, and it ranks the active, enabled causes by a fixed priority.

The receive buffer, the transmit holding stage and the line-status logic sit outside this block. They supply level signals: a receive fill count, a holding-stage-empty flag, a receive-timeout flag and a line-error flag. Software writes the enable register through a write strobe. An identification read strobe marks the cycle in which software samples the code. A holding-stage write strobe marks every byte written for transmission.

The identification code is `{id[2:0], noPending}`. Bit 0 is 1 when nothing is pending.

| Cause | id | Code |
|---|---|---|
| none | 0 | 4'b0001 |
| transmit empty | 1 | 4'b0010 |
| receive data | 2 | 4'b0100 |
| line error | 3 | 4'b0110 |
| receive timeout | 6 | 4'b1100 |

Top module: `uart_irq_top`

## Requirements
- R1: While reset is held and in the cycle after, the enable register reads 3'b000, `idCode` is 4'b0001 and `irq` is 0.
- R2: A write with `enWrEn` high stores `enWrData` into the enable register, visible on `enOut` from the next cycle. Bit 0 enables receive data and timeout, bit 1 enables transmit empty, and bit 2 enables line error.
- R3: With `fifoMode` low, receive data is pending whenever `rxCount` is nonzero and bit 0 is set, giving code 4'b0100 in the same cycle. It stops as soon as `rxCount` returns to 0.
- R4: With `fifoMode` high, receive data is pending while `rxCount` is at or above the level chosen by `trigSel`. The levels are 0→1, 1→4, 2→8 and 3→14 bytes.
- R5: `rxTimeout` with bit 0 set gives code 4'b1100 only when `fifoMode` is high. It is ignored when `fifoMode` is low.
- R6: `lineErr` with bit 2 set gives code 4'b0110 in the same cycle, whatever else is pending.
- R7: Priority, from highest to lowest, is line error, receive data, receive timeout, transmit empty.
- R8: The transmit-empty flag is set by a clock edge at which `txEmpty` is 1 after being 0 at the previous edge. It is also set by an enable write that turns bit 1 from 0 to 1 while `txEmpty` is 1. With bit 1 set and nothing higher pending, code 4'b0010 appears in the next cycle.
- R9: A `holdWrEn` pulse clears the transmit-empty flag from the next cycle on, and it overrides a set in the same cycle.
- R10: An `idRdEn` pulse clears the transmit-empty flag only when the code presented in that cycle is 4'b0010. A read that reports another cause leaves the flag pending.
- R11: `irq` equals the inverse of `idCode[0]`. The code is 4'b0001 whenever no enabled cause is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enWrEn | input | 1 | Enable register write strobe |
| enWrData | input | 3 | Enable register write value |
| enOut | output | 3 | Enable register contents |
| fifoMode | input | 1 | 1 selects buffered (FIFO) receive behaviour |
| trigSel | input | 2 | Receive trigger level select |
| idRdEn | input | 1 | Identification code read strobe |
| holdWrEn | input | 1 | Transmit holding stage write strobe |
| txEmpty | input | 1 | Transmit holding stage (or FIFO) is empty |
| rxCount | input | CW (5) | Bytes held in the receive buffer |
| rxTimeout | input | 1 | Receive character timeout condition |
| lineErr | input | 1 | Receiver line error (parity, framing, break, overrun) |
| irq | output | 1 | Interrupt request |
| idCode | output | 4 | Identification code of the top pending cause |

## Verification
Every output except `enOut` is combinational from live inputs and two registers. A fault in comparison, masking or ranking therefore shows on `idCode` in the very cycle its inputs are applied. A fault in the transmit-empty flag appears one cycle after the edge that should have set or cleared it. It stays visible until a later write or read resets that flag, so a missed clear or a spurious set surfaces once higher causes drop away. The bench keeps a behavioural model of the enable register and the flag and compares `idCode`, `irq` and `enOut` on every cycle. This covers directed corner cases and a long run of random strobes.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    ID_NONE = 3'd0,
    ID_TXE  = 3'd1,
    ID_RXD  = 3'd2,
    ID_LSE  = 3'd3,
    ID_RTO  = 3'd6
  } srcId_t;

  // control -> datapath strobes
  typedef struct packed {
    logic rxEn;
    logic txEn;
    logic lsEn;
    logic txPend;
  } ctrlStrobe_t;

  localparam int NUM_TRIG = 4;

  function automatic int unsigned trigLevel(input int unsigned sel, input int unsigned depth);
    int unsigned lvl;
    case (sel)
      0:       lvl = 1;
      1:       lvl = 4;
      2:       lvl = 8;
      default: lvl = 14;
    endcase
    return (lvl > depth) ? depth : lvl;
  endfunction

endpackage

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enWrEn,
  input  logic [2:0]  enWrData,
  input  logic        idRdEn,
  input  logic        holdWrEn,
  input  logic        txEmpty,
  input  srcId_t      reportedId,
  output logic [2:0]  enReg,
  output ctrlStrobe_t strobes
);

  logic [2:0] enQ;
  logic       txPendQ;
  logic       txEmptyPrevQ;
  logic       txSet;
  logic       txClr;
  logic       txEnRise;

  assign txEnRise = enWrEn && enWrData[1] && !enQ[1];
  assign txSet    = (txEmpty && !txEmptyPrevQ) || (txEnRise && txEmpty);
  assign txClr    = holdWrEn || (idRdEn && (reportedId == ID_TXE));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ          <= '0;
      txPendQ      <= 1'b0;
      txEmptyPrevQ <= 1'b1;
    end else begin
      if (enWrEn) enQ <= enWrData;
      txEmptyPrevQ <= txEmpty;
      if (txClr)      txPendQ <= 1'b0;
      else if (txSet) txPendQ <= 1'b1;
    end
  end

  assign enReg          = enQ;
  assign strobes.rxEn   = enQ[0];
  assign strobes.txEn   = enQ[1];
  assign strobes.lsEn   = enQ[2];
  assign strobes.txPend = txPendQ;

endmodule

// File: rtl/uart_irq_dp.sv
module uart_irq_dp
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  ctrlStrobe_t   strobes,
  input  logic          fifoMode,
  input  logic [1:0]    trigSel,
  input  logic [CW-1:0] rxCount,
  input  logic          rxTimeout,
  input  logic          lineErr,
  output srcId_t        srcId,
  output logic          irq,
  output logic [3:0]    idCode
);

  logic [CW-1:0] lvlTab [NUM_TRIG];

  for (genvar g = 0; g < NUM_TRIG; g++) begin : gLvl
    assign lvlTab[g] = CW'(trigLevel(g, DEPTH));
  end

  logic rxHit, lsAct, rxAct, toAct, txAct;

  assign rxHit = fifoMode ? (rxCount >= lvlTab[trigSel]) : (rxCount != '0);
  assign lsAct = lineErr && strobes.lsEn;
  assign rxAct = rxHit && strobes.rxEn;
  assign toAct = fifoMode && rxTimeout && strobes.rxEn;
  assign txAct = strobes.txPend && strobes.txEn;

  always_comb begin
    if (lsAct)      srcId = ID_LSE;
    else if (rxAct) srcId = ID_RXD;
    else if (toAct) srcId = ID_RTO;
    else if (txAct) srcId = ID_TXE;
    else            srcId = ID_NONE;
  end

  assign irq    = lsAct || rxAct || toAct || txAct;
  assign idCode = {srcId, (srcId == ID_NONE)};

endmodule

// File: rtl/uart_irq_top.sv
module uart_irq_top
  import uart_irq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enWrEn,
  input  logic [2:0]    enWrData,
  output logic [2:0]    enOut,
  input  logic          fifoMode,
  input  logic [1:0]    trigSel,
  input  logic          idRdEn,
  input  logic          holdWrEn,
  input  logic          txEmpty,
  input  logic [CW-1:0] rxCount,
  input  logic          rxTimeout,
  input  logic          lineErr,
  output logic          irq,
  output logic [3:0]    idCode
);

  ctrlStrobe_t strobes;
  srcId_t      srcId;

  uart_irq_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enWrEn     (enWrEn),
    .enWrData   (enWrData),
    .idRdEn     (idRdEn),
    .holdWrEn   (holdWrEn),
    .txEmpty    (txEmpty),
    .reportedId (srcId),
    .enReg      (enOut),
    .strobes    (strobes)
  );

  uart_irq_dp #(.DEPTH(DEPTH), .CW(CW)) uDp (
    .strobes   (strobes),
    .fifoMode  (fifoMode),
    .trigSel   (trigSel),
    .rxCount   (rxCount),
    .rxTimeout (rxTimeout),
    .lineErr   (lineErr),
    .srcId     (srcId),
    .irq       (irq),
    .idCode    (idCode)
  );

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          enWrEn,
  input logic [2:0]    enOut,
  input logic          fifoMode,
  input logic          idRdEn,
  input logic          holdWrEn,
  input logic          txEmpty,
  input logic [CW-1:0] rxCount,
  input logic          lineErr,
  input logic          irq,
  input logic [3:0]    idCode
);

  logic seenEmpty;
  always_ff @(posedge clk) begin
    if (!rstN) seenEmpty <= 1'b1;
    else       seenEmpty <= txEmpty;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> (enOut == 3'b000 && idCode == 4'b0001 && !irq));

  assert_irq_code_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq == !idCode[0]);

  assert_line_first_R6: assert property (@(posedge clk) disable iff (!rstN)
    (lineErr && enOut[2]) |-> idCode == 4'b0110);

  assert_rx_plain_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && enOut[0] && rxCount != '0 && !(lineErr && enOut[2])) |-> idCode == 4'b0100);

  assert_tx_wr_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    holdWrEn |=> idCode != 4'b0010);

  assert_tx_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    (txEmpty && !seenEmpty && enOut[1] && !enWrEn && !holdWrEn && !idRdEn) |=> !idCode[0]);

endmodule

bind uart_irq_top uart_irq_chk #(.CW(CW)) uChk (.*);

// File: tb/tb_uart_irq_top.sv
module tb_uart_irq_top;
  localparam int DEPTH = 16;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rstN = 1'b0;
  logic          enWrEn = 1'b0;
  logic [2:0]    enWrData = '0;
  logic [2:0]    enOut;
  logic          fifoMode = 1'b0;
  logic [1:0]    trigSel = '0;
  logic          idRdEn = 1'b0;
  logic          holdWrEn = 1'b0;
  logic          txEmpty = 1'b1;
  logic [CW-1:0] rxCount = '0;
  logic          rxTimeout = 1'b0;
  logic          lineErr = 1'b0;
  logic          irq;
  logic [3:0]    idCode;

  uart_irq_top #(.DEPTH(DEPTH)) dut (.*);

  int testsRun = 0;
  int testsFailed = 0;
  bit done = 1'b0;

  // behavioural model state
  int mEn = 0;
  int mPend = 0;
  int mPrev = 1;

  function automatic int lvlOf(input int sel);
    int l;
    l = (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    return (l > DEPTH) ? DEPTH : l;
  endfunction

  function automatic int expCode();
    int cnt;
    bit rxOk;
    cnt  = int'(rxCount);
    rxOk = fifoMode ? (cnt >= lvlOf(int'(trigSel))) : (cnt > 0);
    if (lineErr && mEn[2]) return 6;
    if (rxOk && mEn[0]) return 4;
    if (fifoMode && rxTimeout && mEn[0]) return 12;
    if (mPend != 0 && mEn[1]) return 2;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mPend = 0; mPrev = 1;
    end else begin
      int code;
      code = expCode();
      if (holdWrEn) mPend = 0;
      else if (idRdEn && code == 2) mPend = 0;
      else if ((txEmpty && mPrev == 0) || (enWrEn && enWrData[1] && !mEn[1] && txEmpty)) mPend = 1;
      if (enWrEn) mEn = int'(enWrData);
      mPrev = txEmpty ? 1 : 0;
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk(int'(idCode), expCode(), "R7 model idCode");
      chk(int'(irq), (expCode() != 1) ? 1 : 0, "R11 model irq");
      chk(int'(enOut), mEn, "R2 model enOut");
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      testsFailed++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    #2;
    chk(int'(idCode), 1, "R1 reset code");
    chk(int'(irq), 0, "R1 reset irq");
    chk(int'(enOut), 0, "R1 reset enables");
    cyc(); rstN = 1'b1;
    #2 chk(int'(idCode), 1, "R1 after reset");

    cyc(); enWrEn = 1'b1; enWrData = 3'b111;
    cyc(); enWrEn = 1'b0;
    #2 chk(int'(enOut), 7, "R2 enable write");
    chk(int'(idCode), 2, "R8 enable while empty");
    chk(int'(irq), 1, "R11 irq high");

    cyc(); idRdEn = 1'b1;
    cyc(); idRdEn = 1'b0;
    #2 chk(int'(idCode), 1, "R10 read clears tx");

    cyc(); txEmpty = 1'b0; holdWrEn = 1'b1;
    cyc(); holdWrEn = 1'b0; txEmpty = 1'b1;
    cyc();
    #2 chk(int'(idCode), 2, "R8 empty edge");
    holdWrEn = 1'b1;
    cyc(); holdWrEn = 1'b0;
    #2 chk(int'(idCode), 1, "R9 write clears tx");

    rxCount = 1;
    #2 chk(int'(idCode), 4, "R3 byte present");
    rxCount = 0;
    #2 chk(int'(idCode), 1, "R3 buffer read");

    rxTimeout = 1'b1;
    #2 chk(int'(idCode), 1, "R5 timeout ignored plain mode");
    fifoMode = 1'b1;
    #2 chk(int'(idCode), 12, "R5 timeout buffered mode");
    rxTimeout = 1'b0;

    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      rxCount = CW'(lvlOf(s) - 1);
      #2 chk(int'(idCode), 1, "R4 below trigger");
      rxCount = CW'(lvlOf(s));
      #2 chk(int'(idCode), 4, "R4 at trigger");
    end

    lineErr = 1'b1;
    #2 chk(int'(idCode), 6, "R6 line error first");
    cyc(); enWrEn = 1'b1; enWrData = 3'b011;
    cyc(); enWrEn = 1'b0;
    #2 chk(int'(enOut), 3, "R2 line disabled");
    chk(int'(idCode), 4, "R2 masked line error");
    lineErr = 1'b0;

    cyc(); txEmpty = 1'b0;
    cyc(); txEmpty = 1'b1;
    cyc();
    #2 chk(int'(idCode), 4, "R7 rx over tx");
    idRdEn = 1'b1;
    cyc(); idRdEn = 1'b0; rxCount = 0;
    #2 chk(int'(idCode), 2, "R10 read of other cause keeps tx");
    rxTimeout = 1'b1;
    #2 chk(int'(idCode), 12, "R7 timeout over tx");
    rxTimeout = 1'b0;

    cyc(); enWrEn = 1'b1; enWrData = 3'b000;
    cyc(); enWrEn = 1'b0;
    #2 chk(int'(idCode), 1, "R11 nothing enabled");
    chk(int'(irq), 0, "R11 irq low");

    for (int i = 0; i < 4000; i++) begin
      cyc();
      enWrEn    = ($urandom_range(0, 15) == 0);
      enWrData  = 3'($urandom);
      idRdEn    = ($urandom_range(0, 3) == 0);
      holdWrEn  = ($urandom_range(0, 5) == 0);
      txEmpty   = ($urandom_range(0, 2) != 0);
      rxCount   = CW'($urandom_range(0, DEPTH));
      rxTimeout = ($urandom_range(0, 4) == 0);
      lineErr   = ($urandom_range(0, 7) == 0);
      trigSel   = 2'($urandom);
      if ($urandom_range(0, 31) == 0) fifoMode = ~fifoMode;
    end

    cyc();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule